// File: doc/BRIEF.md
# Soft Power Toggle Qualifier

This block watches a slow, asynchronous push-button style control line and decides when the line has carried one deliberate toggle: a rest at low, a high phase, and a return to low. The raw line first passes through a two-stage synchronizer. It then goes through a debouncer that accepts a new level only after the level has stayed unchanged for a set number of microsecond ticks. A state machine measures the high phase in ticks. It accepts the toggle only when the high phase is longer than a lower limit and shorter than an upper limit.

Each accepted toggle produces a one-cycle event strobe, and the strobe serves as a wake interrupt. The same event flips a mode flag between normal (0) and hibernate (1). A warning flag is updated on every event. It reports whether that event followed the previous accepted event by less than a minimum spacing.

The state machine has four states. `ST_WAIT_LOW` is the state after reset: the line has not yet been seen low, and a clean fall moves to `ST_ARMED`. In `ST_ARMED` the line is low, and a clean rise moves to `ST_HIGH`. `ST_HIGH` counts the width of the high phase. A clean fall returns to `ST_ARMED`, and that fall is accepted only if the width is inside the window. If the width reaches the upper limit before a fall, the machine moves to `ST_REJECT`. `ST_REJECT` waits for a clean fall and then returns to `ST_ARMED` without an event.

Top module: `toggle_qualifier`

## Requirements
- R1: A change of the synchronized line is taken as a clean edge only after the new level has held for DEB_TICKS consecutive `us_tick` pulses. Shorter glitches produce no event and leave `mode_hib` unchanged.
- R2: An event needs a clean low, then a clean high, then a clean low. A line that is high at reset produces no event on its first fall.
- R3: A high phase of MIN_HIGH_US ticks or fewer is rejected.
- R4: A high phase that reaches MAX_HIGH_US ticks is rejected. After the later fall the block is armed again.
- R5: An accepted toggle raises `toggle_evt` for exactly one cycle. The strobe follows the qualified falling edge and is never raised while the line is high.
- R6: `mode_hib` (0 = normal, 1 = hibernate) inverts in the cycle after each event and changes at no other time. Its reset value is RESET_HIBERNATE.
- R7: On each event, `too_soon` becomes 1 if an earlier event occurred less than MIN_GAP_US ticks before. Otherwise it becomes 0, which includes the first event after reset. It holds its value between events.
- R8: After reset `toggle_evt` and `too_soon` are 0.
- R9: Bounce of single-tick pulses around both edges of a valid toggle yields exactly one event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_raw | input | 1 | Asynchronous soft power control line |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| toggle_evt | output | 1 | One-cycle strobe for an accepted toggle (wake interrupt) |
| mode_hib | output | 1 | Current mode: 0 normal, 1 hibernate |
| too_soon | output | 1 | Last event came less than the minimum spacing after the one before |

## Verification
A wrong state or width count inside the block shows up at the ports as an event that is missing, duplicated or spurious. It becomes visible within a few ticks of the qualifying fall, or even during the high phase, and `mode_hib` then flips one cycle after that. A debouncer that is off by one shows up on glitches of one or two ticks and on pulses near the lower width limit. A spacing counter that is wrong shows up as a wrong `too_soon` level on the next event. Because each event pushes its expected mode and warning into a queue, the first wrong item is reported at the event where it occurs.

// File: rtl/toggle_qual_pkg.sv
package toggle_qual_pkg;

    typedef enum logic [1:0] {
        ST_WAIT_LOW = 2'd0,
        ST_ARMED    = 2'd1,
        ST_HIGH     = 2'd2,
        ST_REJECT   = 2'd3
    } tq_state_e;

endpackage

// File: rtl/tq_sync2.sv
module tq_sync2 #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic d_sync
);
    logic meta_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            d_sync <= RST_VAL;
        end else begin
            meta_q <= d_async;
            d_sync <= meta_q;
        end
    end
endmodule

// File: rtl/tq_debounce.sv
module tq_debounce #(
    parameter int unsigned STABLE_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_in,
    input  logic tick,
    output logic rise,
    output logic fall
);
    localparam int unsigned CW = (STABLE_TICKS < 2) ? 1 : $clog2(STABLE_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(STABLE_TICKS - 1);

    logic [CW-1:0] cnt_q;
    logic          clean_q;
    logic          commit;

    // the differing level has now lasted the full window
    assign commit = (lvl_in != clean_q) && tick && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            clean_q <= 1'b1;
            rise    <= 1'b0;
            fall    <= 1'b0;
        end else begin
            rise <= commit && lvl_in;
            fall <= commit && !lvl_in;
            if (lvl_in == clean_q) begin
                cnt_q <= '0;
            end else if (commit) begin
                clean_q <= lvl_in;
                cnt_q   <= '0;
            end else if (tick) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R1: clean level only moves on a tick edge
    p_change_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (clean_q != $past(clean_q)) |-> $past(tick));
    // R1: edge pulses agree with the clean level they report
    p_rise_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rise |-> (clean_q && !fall));
    p_fall_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fall |-> !clean_q);
endmodule

// File: rtl/tq_width_fsm.sv
module tq_width_fsm
    import toggle_qual_pkg::*;
#(
    parameter int unsigned MIN_HIGH_US = 62,
    parameter int unsigned MAX_HIGH_US = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic rise,
    input  logic fall,
    output logic evt
);
    localparam int unsigned WW = $clog2(MAX_HIGH_US + 1);
    localparam logic [WW-1:0] MIN_L  = WW'(MIN_HIGH_US);
    localparam logic [WW-1:0] MAX_L  = WW'(MAX_HIGH_US);
    localparam logic [WW-1:0] NEAR_L = WW'(MAX_HIGH_US - 1);

    tq_state_e     state_q, state_d;
    logic [WW-1:0] wcnt_q;
    logic          accept;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_WAIT_LOW;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT_LOW: if (fall) state_d = ST_ARMED;
            ST_ARMED:    if (rise) state_d = ST_HIGH;
            ST_HIGH: begin
                if (fall)                           state_d = ST_ARMED;
                else if (tick && wcnt_q == NEAR_L)  state_d = ST_REJECT;
            end
            ST_REJECT:   if (fall) state_d = ST_ARMED;
            default:     state_d = ST_WAIT_LOW;
        endcase
    end

    // width counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt_q <= '0;
        end else if (state_q == ST_ARMED && rise) begin
            wcnt_q <= '0;
        end else if (state_q == ST_HIGH && tick && wcnt_q != MAX_L) begin
            wcnt_q <= wcnt_q + 1'b1;
        end
    end

    assign accept = (state_q == ST_HIGH) && fall && (wcnt_q > MIN_L);

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) evt <= 1'b0;
        else        evt <= accept;
    end

    p_wcnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wcnt_q <= MAX_L);
    p_reject_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REJECT) |=> !evt);
    p_short_rejected_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HIGH && fall && wcnt_q <= MIN_L) |=> !evt);
    p_evt_after_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        evt |-> $past(fall));
    p_evt_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> !evt);
    p_first_fall_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_LOW) |=> !evt);
endmodule

// File: rtl/toggle_qualifier.sv
module toggle_qualifier #(
    parameter int unsigned DEB_TICKS       = 4,
    parameter int unsigned MIN_HIGH_US     = 62,
    parameter int unsigned MAX_HIGH_US     = 1000000,
    parameter int unsigned MIN_GAP_US      = 1000000,
    parameter logic        RESET_HIBERNATE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_raw,
    input  logic us_tick,
    output logic toggle_evt,
    output logic mode_hib,
    output logic too_soon
);
    localparam int unsigned GW = $clog2(MIN_GAP_US + 1);
    localparam logic [GW-1:0] GAP_L = GW'(MIN_GAP_US);

    logic          pin_s;
    logic          rise, fall;
    logic [GW-1:0] gap_q;
    logic          seen_q;

    tq_sync2 #(.RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(pin_raw), .d_sync(pin_s)
    );

    tq_debounce #(.STABLE_TICKS(DEB_TICKS)) u_deb (
        .clk(clk), .rst_n(rst_n), .lvl_in(pin_s), .tick(us_tick),
        .rise(rise), .fall(fall)
    );

    tq_width_fsm #(.MIN_HIGH_US(MIN_HIGH_US), .MAX_HIGH_US(MAX_HIGH_US)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(us_tick), .rise(rise), .fall(fall),
        .evt(toggle_evt)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_hib <= RESET_HIBERNATE;
            too_soon <= 1'b0;
            gap_q    <= '0;
            seen_q   <= 1'b0;
        end else if (toggle_evt) begin
            mode_hib <= ~mode_hib;
            too_soon <= seen_q && (gap_q < GAP_L);
            gap_q    <= '0;
            seen_q   <= 1'b1;
        end else if (us_tick && gap_q != GAP_L) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    p_mode_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        toggle_evt |=> (mode_hib != $past(mode_hib)));
    p_mode_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !toggle_evt |=> $stable(mode_hib));
    p_warn_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !toggle_evt |=> $stable(too_soon));
    p_first_warn_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (toggle_evt && !seen_q) |=> !too_soon);
endmodule

// File: tb/tb_toggle_qualifier.sv
module tb_toggle_qualifier;
    localparam int unsigned DEB = 3;
    localparam int unsigned MINW = 10;
    localparam int unsigned MAXW = 50;
    localparam int unsigned GAP = 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pin_raw = 1'b1;
    logic us_tick = 1'b0;
    logic toggle_evt, mode_hib, too_soon;
    logic evt_h, mode_h, ts_h;

    typedef struct packed { logic mode; logic ts; } exp_t;
    exp_t q[$];
    int errors = 0;
    int checks = 0;
    logic exp_mode = 1'b0;
    logic in_high = 1'b0;
    logic pend = 1'b0;
    exp_t cur;

    always #5 clk = ~clk;

    toggle_qualifier #(.DEB_TICKS(DEB), .MIN_HIGH_US(MINW), .MAX_HIGH_US(MAXW),
                       .MIN_GAP_US(GAP), .RESET_HIBERNATE(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .us_tick(us_tick),
        .toggle_evt(toggle_evt), .mode_hib(mode_hib), .too_soon(too_soon));

    toggle_qualifier #(.DEB_TICKS(DEB), .MIN_HIGH_US(MINW), .MAX_HIGH_US(MAXW),
                       .MIN_GAP_US(GAP), .RESET_HIBERNATE(1'b1)) dut_hib (
        .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .us_tick(us_tick),
        .toggle_evt(evt_h), .mode_hib(mode_h), .too_soon(ts_h));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    initial begin
        forever begin
            repeat (3) @(negedge clk);
            us_tick = 1'b1;
            @(negedge clk);
            us_tick = 1'b0;
        end
    end

    task automatic wait_ticks(input int n);
        repeat (n) @(posedge clk iff us_tick == 1'b1);
        @(negedge clk);
    endtask

    // monitor: pop expected item on each event, compare a cycle later
    always @(negedge clk) begin
        if (rst_n) begin
            if (pend) begin
                pend <= 1'b0;
                check(mode_hib == cur.mode, "R6 mode after event", mode_hib, cur.mode);
                check(too_soon == cur.ts, "R7 warning after event", too_soon, cur.ts);
            end
            if (toggle_evt) begin
                check(!in_high, "R5 event while line high", 1, 0);
                if (q.size() == 0) begin
                    check(1'b0, "R3/R4/R9 unexpected event", 1, 0);
                end else begin
                    cur = q.pop_front();
                    pend <= 1'b1;
                end
            end
        end
    end

    task automatic settle_and_check(input string req);
        wait_ticks(DEB + 4);
        check(q.size() == 0, req, q.size(), 0);
        check(mode_hib == exp_mode, req, mode_hib, exp_mode);
    endtask

    task automatic send_pulse(input int width, input bit accept, input bit ts, input string req);
        pin_raw = 1'b1;
        in_high = 1'b1;
        wait_ticks(width);
        pin_raw = 1'b0;
        in_high = 1'b0;
        if (accept) begin
            exp_mode = ~exp_mode;
            q.push_back('{mode: exp_mode, ts: ts});
        end
        settle_and_check(req);
    endtask

    initial begin
        #200000;
        check(1'b0, "watchdog expired", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state, R6 reset values
        check(toggle_evt == 1'b0, "R8 event at reset", toggle_evt, 0);
        check(too_soon == 1'b0, "R8 warning at reset", too_soon, 0);
        check(mode_hib == 1'b0, "R6 reset mode normal", mode_hib, 0);
        check(mode_h == 1'b1, "R6 reset mode hibernate", mode_h, 1);

        // R2: line high at reset, first fall gives nothing
        wait_ticks(5);
        pin_raw = 1'b0;
        wait_ticks(10);
        settle_and_check("R2 first fall after reset");

        // R1: short glitches ignored
        for (int i = 0; i < 3; i++) begin
            pin_raw = 1'b1;
            wait_ticks(1);
            pin_raw = 1'b0;
            wait_ticks(3);
        end
        settle_and_check("R1 glitch filtered");

        // R3: too short
        send_pulse(6, 1'b0, 1'b0, "R3 short pulse rejected");
        send_pulse(8, 1'b0, 1'b0, "R3 pulse near lower limit rejected");

        // R5/R6/R7: first valid toggle, no warning
        send_pulse(20, 1'b1, 1'b0, "R5 valid toggle");
        // R7: second toggle soon after
        send_pulse(20, 1'b1, 1'b1, "R7 close toggle warned");

        // R4: too long, then armed again
        send_pulse(80, 1'b0, 1'b0, "R4 long pulse rejected");
        wait_ticks(120);

        // R9: bounce on both edges, one event, spacing large
        for (int i = 0; i < 2; i++) begin
            pin_raw = 1'b1; wait_ticks(1);
            pin_raw = 1'b0; wait_ticks(1);
        end
        pin_raw = 1'b1;
        in_high = 1'b1;
        wait_ticks(25);
        for (int i = 0; i < 2; i++) begin
            pin_raw = 1'b0; wait_ticks(1);
            pin_raw = 1'b1; wait_ticks(1);
        end
        pin_raw = 1'b0;
        in_high = 1'b0;
        exp_mode = ~exp_mode;
        q.push_back('{mode: exp_mode, ts: 1'b0});
        settle_and_check("R9 bounced toggle single event");

        // R3 boundary: just above lower limit accepted, close spacing
        send_pulse(13, 1'b1, 1'b1, "R3 pulse above lower limit accepted");

        wait_ticks(4);
        check(mode_h == ~exp_mode, "R6 second instance tracks events", mode_h, ~exp_mode);
        check(q.size() == 0, "R5 all events seen", q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule